// File: doc/BRIEF.md
# Countdown Timer Channel with Waveform Output

This block is one timer channel. It holds a 16-bit reload latch and a 16-bit down counter, and it turns the counter's time-outs into a waveform on a single output pin. The counter runs either as one 16-bit word or as two cascaded 8-bit bytes. In the cascaded form the low byte sets the width of the high phase and the high byte sets how many low-byte rounds form the low phase, so one latch value sets both the period and the duty cycle. The channel runs in two modes. In cyclic mode it produces a repeating waveform. In one-shot mode it produces a single pulse for each initialization.

All timing is counted in count-enable strobes (`tick`), which come from an upstream clock synchronizer. The gate level, the gate falling-edge event and the latch-write event also arrive already synchronized to `clk`. On each cycle the channel reports its live counter value, a one-cycle time-out pulse and a sticky time-out flag. An initialization clears that flag.

Top module: `tmr_channel`

## Requirements
- R1: With `rst` high at a clock edge, the latch and the counter take 16'hFFFF, and `tmr_out`, `tout` and `flag` are low after that edge. `rst` wins over every other input in the same cycle.
- R2: In word mode (`cascade_8`=0) with latch value N, `tout` pulses for one cycle after the (N+1)-th counted tick following an initialization. That tick reloads the counter from the latch.
- R3: In byte mode (`cascade_8`=1), the latch is read as M in bits 15:8 and L in bits 7:0, and `count` uses the same layout. A counted tick with low byte 0 and a nonzero counter reloads the low byte from L and decrements the high byte. Time-out occurs every (L+1)(M+1) counted ticks.
- R4: In byte mode with L≠0, the waveform is low after initialization. It goes high on a counted tick taken while the high byte is 0, and it goes low at time-out. For M=3 and L=4 that gives 16 low and 4 high out of every 20 ticks.
- R5: In byte mode with L=0, time-out occurs every M+1 ticks and the cyclic waveform toggles at each time-out. With M=L=0 the counter stays at 0 and the waveform toggles on every counted tick.
- R6: In word mode with cyclic operation, the waveform starts low at initialization and toggles at every time-out.
- R7: In cyclic mode a tick counts only while `gate_lvl` is 0. Otherwise the counter holds. `gate_fall` initializes the counter. `latch_wr` initializes it when `wr_init_dis`=0; when `wr_init_dis`=1 it only updates the latch.
- R8: Every time-out sets `flag` and reloads the counter, in either mode. An initialization copies the latch into the counter and clears `flag`.
- R9: In one-shot mode (`mode_single`=1) the gate level is ignored for counting. The waveform goes high once after an initialization and falls at the first time-out. It then stays low while the counter keeps cycling.
- R10: In one-shot mode with N=0 (word mode) or M=L=0 (byte mode), `tmr_out` stays low.
- R11: One cycle after `out_en` is sampled low, `tmr_out` is low. The counter and the waveform keep running underneath.
- R12: An initialization in the same cycle as a tick loads the latch value (including a value written in that cycle), and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe, one per synchronized count clock |
| gate_lvl | input | 1 | Synchronized gate level; high blocks counting in cyclic mode |
| gate_fall | input | 1 | One-cycle gate falling-edge event, initializes the counter |
| latch_wr | input | 1 | Latch write strobe |
| latch_din | input | 16 | Latch write data |
| mode_single | input | 1 | 1 = one-shot, 0 = cyclic |
| cascade_8 | input | 1 | 1 = two cascaded 8-bit counts, 0 = one 16-bit count |
| wr_init_dis | input | 1 | 1 = latch write does not initialize the counter |
| out_en | input | 1 | Output enable, takes effect one cycle later |
| tmr_out | output | 1 | Waveform output pin |
| tout | output | 1 | One-cycle time-out pulse |
| flag | output | 1 | Sticky time-out flag, cleared by initialization |
| count | output | 16 | Live counter value |

## Verification
An initialization, caused by a gate falling edge or by a latch write, can arrive in the same cycle as a counted tick. That tick may also be the one that would time out. The clash decides whether the counter loads or steps and whether the flag is set or cleared. Random stimulus with frequent strobes and small latch values forces this overlap many times, and directed cases add a write, a gate edge and a reset on top of a tick. A bench model derived from the requirements predicts the counter, the pulse, the flag and the pin in every cycle, and the design is compared with it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef enum logic {
        RUN_CYCLIC  = 1'b0,
        RUN_ONESHOT = 1'b1
    } run_e;

    typedef enum logic {
        WIDTH_WORD  = 1'b0,
        WIDTH_BYTES = 1'b1
    } width_e;

    // one step of the plain 16-bit count
    function automatic cnt_t step_word(cnt_t c);
        logic [WORD_W-1:0] v;
        v = c;
        v = v - WORD_W'(1);
        return cnt_t'(v);
    endfunction

    // one step of the cascaded byte count
    function automatic cnt_t step_bytes(cnt_t c, logic [BYTE_W-1:0] lo_reload);
        cnt_t r;
        if (c.lo == '0) begin
            r.hi = c.hi - BYTE_W'(1);
            r.lo = lo_reload;
        end else begin
            r.hi = c.hi;
            r.lo = c.lo - BYTE_W'(1);
        end
        return r;
    endfunction

    // the waveform follows time-outs only (no high-byte phase)
    function automatic logic is_wide(width_e w, logic [BYTE_W-1:0] lo_latch);
        return (w == WIDTH_WORD) || (lo_latch == '0);
    endfunction

endpackage

// File: rtl/tmr_latch.sv
module tmr_latch
    import tmr_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] din,
    output cnt_t              q,
    output cnt_t              q_nxt
);

    assign q_nxt = wr ? cnt_t'(din) : q;

    always_ff @(posedge clk) begin
        if (rst) q <= cnt_t'(RST_VAL);
        else     q <= q_nxt;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   init,
    input  logic   step,
    input  width_e width,
    input  cnt_t   load_val,
    input  cnt_t   reload_val,
    output cnt_t   cnt,
    output logic   tmo,
    output logic   hi_zero
);

    cnt_t nxt;

    assign tmo     = step && (cnt == '0);
    assign hi_zero = (cnt.hi == '0);

    always_comb begin
        nxt = cnt;
        if (init)       nxt = load_val;
        else if (tmo)   nxt = reload_val;
        else if (step) begin
            if (width == WIDTH_BYTES) nxt = step_bytes(cnt, reload_val.lo);
            else                      nxt = step_word(cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= cnt_t'(RST_VAL);
        else     cnt <= nxt;
    end

    // without a step or an initialization the count holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!init && !step) |=> $stable(cnt));

    // a time-out restarts from the latch
    p_reload_r2: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (cnt == $past(reload_val)));

    // cascade borrow: low byte reloads, high byte drops by one
    p_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !init && width == WIDTH_BYTES && cnt.lo == '0 && cnt.hi != '0)
        |=> (cnt.hi == $past(cnt.hi) - BYTE_W'(1)) && (cnt.lo == $past(reload_val.lo)));

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic step,
    input  logic tmo,
    input  run_e run,
    input  logic wide,
    input  logic hi_zero,
    input  logic oe,
    output logic pin,
    output logic flag,
    output logic tout
);

    logic wave, wave_n;
    logic armed, armed_n;
    logic flag_n;
    logic oe_q;

    always_comb begin
        wave_n  = wave;
        armed_n = armed;
        flag_n  = flag;
        if (init) begin
            wave_n  = 1'b0;
            armed_n = 1'b1;
            flag_n  = 1'b0;
        end else if (tmo) begin
            flag_n  = 1'b1;
            armed_n = 1'b0;
            wave_n  = (run == RUN_CYCLIC && wide) ? !wave : 1'b0;
        end else if (step) begin
            if (wide) begin
                if (run == RUN_ONESHOT && armed) wave_n = 1'b1;
            end else if (hi_zero && (run == RUN_CYCLIC || armed)) begin
                wave_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave  <= 1'b0;
            armed <= 1'b1;
            flag  <= 1'b0;
            tout  <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            wave  <= wave_n;
            armed <= armed_n;
            flag  <= flag_n;
            tout  <= tmo;
            oe_q  <= oe;
        end
    end

    assign pin = oe_q & wave;

    p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (flag && tout));

    p_init_clear_r8: assert property (@(posedge clk) disable iff (rst)
        init |=> (!flag && !tout && !pin));

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (tmo && run == RUN_ONESHOT) |=> !pin);

    p_oe_low_r11: assert property (@(posedge clk) disable iff (rst)
        !oe |=> !pin);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter logic [WORD_W-1:0] LATCH_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate_lvl,
    input  logic              gate_fall,
    input  logic              latch_wr,
    input  logic [WORD_W-1:0] latch_din,
    input  logic              mode_single,
    input  logic              cascade_8,
    input  logic              wr_init_dis,
    input  logic              out_en,
    output logic              tmr_out,
    output logic              tout,
    output logic              flag,
    output logic [WORD_W-1:0] count
);

    run_e   run;
    width_e width;
    cnt_t   latch_q, latch_nxt, cnt_q;
    logic   init, en, step, tmo, hi_zero, wide;

    assign run   = run_e'(mode_single);
    assign width = width_e'(cascade_8);
    assign init  = gate_fall | (latch_wr & ~wr_init_dis);
    assign en    = tick & ((run == RUN_ONESHOT) | ~gate_lvl);
    assign step  = en & ~init;
    assign wide  = is_wide(width, latch_q.lo);
    assign count = cnt_q;

    tmr_latch #(.RST_VAL(LATCH_RST)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .wr    (latch_wr),
        .din   (latch_din),
        .q     (latch_q),
        .q_nxt (latch_nxt)
    );

    tmr_counter #(.RST_VAL(LATCH_RST)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .init       (init),
        .step       (step),
        .width      (width),
        .load_val   (latch_nxt),
        .reload_val (latch_q),
        .cnt        (cnt_q),
        .tmo        (tmo),
        .hi_zero    (hi_zero)
    );

    tmr_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .init    (init),
        .step    (step),
        .tmo     (tmo),
        .run     (run),
        .wide    (wide),
        .hi_zero (hi_zero),
        .oe      (out_en),
        .pin     (tmr_out),
        .flag    (flag),
        .tout    (tout)
    );

    // initialization wins over a same-cycle tick and loads the fresh latch
    p_init_load_r12: assert property (@(posedge clk) disable iff (rst)
        init |=> (count == latch_q));

endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, gate_lvl = 1'b0, gate_fall = 1'b0, latch_wr = 1'b0;
    logic [15:0] din = '0;
    logic        single = 1'b0, dual = 1'b0, wr_init_dis = 1'b0, out_en = 1'b0;
    logic        tmr_out, tout, flag;
    logic [15:0] count;

    int checks = 0, fails = 0;
    int hi_cnt = 0, to_cnt = 0;
    string tag = "R1";
    bit done = 1'b0;

    logic [15:0] m_latch, m_cnt;
    logic        m_wave, m_armed, m_flag, m_tout, m_oen;

    always #2 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst(rst), .tick(tick), .gate_lvl(gate_lvl), .gate_fall(gate_fall),
        .latch_wr(latch_wr), .latch_din(din), .mode_single(single), .cascade_8(dual),
        .wr_init_dis(wr_init_dis), .out_en(out_en),
        .tmr_out(tmr_out), .tout(tout), .flag(flag), .count(count)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic model_step();
        logic [15:0] nl;
        logic init, en, wide, hz;
        if (rst) begin
            m_latch = 16'hFFFF; m_cnt = 16'hFFFF; m_wave = 0; m_armed = 1;
            m_flag = 0; m_tout = 0; m_oen = 0;
        end else begin
            nl   = latch_wr ? din : m_latch;
            init = gate_fall | (latch_wr & ~wr_init_dis);
            en   = tick & (single | ~gate_lvl);
            wide = ~dual | (m_latch[7:0] == 8'd0);
            hz   = (m_cnt[15:8] == 8'd0);
            m_tout = 0;
            if (init) begin
                m_cnt = nl; m_flag = 0; m_wave = 0; m_armed = 1;
            end else if (en) begin
                if (m_cnt == 16'd0) begin
                    m_tout = 1; m_flag = 1; m_cnt = m_latch; m_armed = 0;
                    m_wave = (~single & wide) ? ~m_wave : 1'b0;
                end else begin
                    if (dual) begin
                        if (m_cnt[7:0] == 8'd0) m_cnt = {m_cnt[15:8] - 8'd1, m_latch[7:0]};
                        else m_cnt[7:0] = m_cnt[7:0] - 8'd1;
                    end else m_cnt = m_cnt - 16'd1;
                    if (wide) begin
                        if (single & m_armed) m_wave = 1;
                    end else if (hz & (~single | m_armed)) m_wave = 1;
                end
            end
            m_latch = nl;
            m_oen = out_en;
        end
    endtask

    task automatic step1();
        logic e_out;
        model_step();
        @(posedge clk);
        #1;
        e_out = m_oen & m_wave;
        chk(count == m_cnt && tout == m_tout && flag == m_flag && tmr_out == e_out,
            {tag, " model compare {count,tout,flag,out}"},
            {count, tout, flag, tmr_out}, {m_cnt, m_tout, m_flag, e_out});
        hi_cnt += int'(tmr_out);
        to_cnt += int'(tout);
        @(negedge clk);
        gate_fall = 0; latch_wr = 0; rst = 0;
    endtask

    task automatic ticks(input int n);
        tick = 1;
        for (int i = 0; i < n; i++) step1();
        tick = 0;
    endtask

    task automatic setup(input bit s, input bit d, input logic [15:0] v);
        single = s; dual = d; wr_init_dis = 0; out_en = 1; gate_lvl = 0;
        din = v; latch_wr = 1; tick = 0;
        step1();
        hi_cnt = 0; to_cnt = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        rst = 1; tag = "R1"; step1();
        chk(count == 16'hFFFF, "R1 count after reset", count, 16'hFFFF);
        chk(!tmr_out && !tout && !flag, "R1 outputs low after reset", {tmr_out, tout, flag}, 0);

        // R2 / R6 word cyclic, N=5
        tag = "R2"; setup(0, 0, 16'd5);
        ticks(6);
        chk(to_cnt == 1 && tout, "R2 timeout on 6th tick", to_cnt, 1);
        chk(count == 16'd5, "R2 reload after timeout", count, 5);
        tag = "R6"; ticks(6);
        chk(tmr_out == 0 && to_cnt == 2, "R6 square wave toggles back", tmr_out, 0);

        // R3 / R4 bytes M=3 L=4
        tag = "R3"; setup(0, 1, 16'h0304);
        ticks(5);
        chk(count == 16'h0204, "R3 borrow reloads low byte", count, 16'h0204);
        tag = "R4"; hi_cnt = 0; to_cnt = 0;
        ticks(35);
        chk(to_cnt == 2, "R3 timeouts in 40 ticks", to_cnt, 2);
        chk(hi_cnt == 8, "R4 high ticks in 40 (4 of 20)", hi_cnt, 8);

        // R5 L=0
        tag = "R5"; setup(0, 1, 16'h0200);
        ticks(9);
        chk(to_cnt == 3, "R5 timeout every M+1", to_cnt, 3);
        chk(tmr_out == 1, "R5 toggled three times", tmr_out, 1);
        setup(0, 1, 16'h0000);
        ticks(3);
        chk(to_cnt == 3 && count == 0 && tmr_out == 1, "R5 M=L=0 toggles each tick", to_cnt, 3);

        // R7 gating and write initialization
        tag = "R7"; setup(0, 0, 16'd10);
        gate_lvl = 1; ticks(5);
        chk(count == 16'd10, "R7 gate high holds count", count, 10);
        gate_lvl = 0; ticks(3);
        chk(count == 16'd7, "R7 gate low counts", count, 7);
        wr_init_dis = 1; din = 16'd100; latch_wr = 1; step1();
        chk(count == 16'd7, "R7 write without init", count, 7);
        gate_fall = 1; step1();
        chk(count == 16'd100, "R7 gate fall initializes", count, 100);
        wr_init_dis = 0; din = 16'd50; latch_wr = 1; step1();
        chk(count == 16'd50, "R7 write initializes", count, 50);

        // R9 one-shot, gate level ignored
        tag = "R9"; setup(1, 0, 16'd3);
        gate_lvl = 1; ticks(12);
        chk(hi_cnt == 3, "R9 single pulse width", hi_cnt, 3);
        chk(to_cnt == 3, "R9 counter keeps cycling", to_cnt, 3);
        chk(flag == 1, "R8 flag set by timeout", flag, 1);
        tag = "R8"; gate_fall = 1; step1();
        chk(flag == 0, "R8 init clears flag", flag, 0);
        gate_lvl = 0;

        // R10 one-shot with zero latch
        tag = "R10"; setup(1, 0, 16'd0);
        ticks(5);
        chk(hi_cnt == 0 && to_cnt == 5, "R10 no pulse with N=0", hi_cnt, 0);
        setup(1, 1, 16'd0);
        ticks(4);
        chk(hi_cnt == 0, "R10 no pulse with M=L=0", hi_cnt, 0);

        // R11 output enable
        tag = "R11"; setup(0, 0, 16'd2);
        ticks(3);
        chk(tmr_out == 1, "R11 wave high before disable", tmr_out, 1);
        out_en = 0; step1();
        chk(tmr_out == 0, "R11 forced low next cycle", tmr_out, 0);
        ticks(3);
        out_en = 1; step1();
        chk(tmr_out == 0, "R11 wave kept toggling underneath", tmr_out, 0);

        // R12 priorities
        tag = "R12"; setup(0, 0, 16'd20);
        ticks(2);
        din = 16'd9; latch_wr = 1; tick = 1; step1(); tick = 0;
        chk(count == 16'd9, "R12 init beats tick", count, 9);
        rst = 1; gate_fall = 1; tick = 1; step1(); tick = 0;
        chk(count == 16'hFFFF && !flag, "R1 R12 reset beats init", count, 16'hFFFF);

        // mixed random traffic
        tag = "R12 random";
        single = 0; dual = 0; out_en = 1;
        for (int i = 0; i < 6000; i++) begin
            tick      = ($urandom % 4) != 0;
            gate_lvl  = ($urandom % 8) == 0;
            gate_fall = ($urandom % 40) == 0;
            latch_wr  = ($urandom % 50) == 0;
            din       = {8'($urandom % 4), 8'($urandom % 6)};
            if (($urandom % 150) == 0) begin
                single = $urandom; dual = $urandom; wr_init_dis = $urandom; out_en = $urandom;
            end
            rst = ($urandom % 2000) == 0;
            if (i == 0) begin latch_wr = 1; wr_init_dis = 0; end
            step1();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule